// File: doc/BRIEF.md
# Duty-Cycled Supply Monitor Controller

This block is the digital controller that sits beside an analog supply-voltage comparator. It runs on a slow clock and decides when the comparator is powered. The comparator can be powered on every cycle, or for a single slow-clock cycle out of every 32, 256 or 2048 cycles. Duty-cycling cuts the comparator's average current by that same factor.

On each cycle in which the comparator is powered, the controller captures the comparator's below-threshold output. It keeps two copies of that result: a live bit that holds the latest sample, and a sticky bit that latches any detection until software reads the status register. A detection can raise three outputs, each behind its own enable bit: an interrupt, a core reset request and a core wake-up request.

A small register port lets software set three things: the 4-bit threshold code that goes to the analog side unchanged, the sampling mode, and the three enables. Reads return data combinationally in the cycle the read strobe is high.

Top module: `supmon_ctrl`

## Requirements
- R1: A mode field value of 0 (off), or any of the reserved values 5, 6 and 7, keeps `cmp_en` low in every cycle.
- R2: Mode value 1 (continuous) holds `cmp_en` high in every cycle, and the live bit takes a new comparator sample at every clock edge.
- R3: Mode values 2, 3 and 4 raise `cmp_en` for exactly one cycle in every 32, 256 and 2048 cycles respectively. A register write that changes the mode restarts the window, so `cmp_en` is high in the cycle right after that write.
- R4: The live bit loads `cmp_below` only at the end of a cycle in which `cmp_en` is high. In every other cycle it keeps its value, whatever `cmp_below` does.
- R5: A detection (`cmp_en` and `cmp_below` both high in the same cycle) sets the sticky bit at the end of that cycle. A read of the status register returns the current value and then clears the sticky bit.
- R6: If a detection happens in the same cycle as a status read, the sticky bit stays set.
- R7: `irq` is high exactly while the sticky bit is set and the interrupt enable (control bit 4) is 1.
- R8: `core_rst_req` is high for one cycle, in the cycle that follows a detection cycle, and only when the reset enable (control bit 5) is 1.
- R9: `core_wake_req` is high for one cycle, in the cycle that follows a detection cycle, and only when the wake-up enable (control bit 6) is 1.
- R10: `cmp_thresh` always equals the 4-bit threshold register, which is written from `wdata[3:0]` at address 0.
- R11: The register map is: address 0 holds the threshold in bits 3:0; address 1 holds the mode in bits 2:0 and the interrupt, reset and wake enables in bits 4, 5 and 6; address 2 is the status register, with the live bit at bit 0 and the sticky bit at bit 1. All other bits read as 0, and the registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a read of address 2 clears the sticky bit) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while `rd_en` is high |
| cmp_below | input | 1 | Comparator output, high when the supply is below the threshold |
| cmp_en | output | 1 | Comparator power enable |
| cmp_thresh | output | 4 | Threshold code sent to the comparator |
| irq | output | 1 | Interrupt |
| core_rst_req | output | 1 | Core reset request pulse |
| core_wake_req | output | 1 | Core wake-up request pulse |

## Verification
The bench keeps `cmp_below` high through the gap between two sampling windows. A controller that sampled outside the enabled cycle would then show a detection early. It measures the spacing of `cmp_en` pulses for all three periods, so an off-by-one window length shows up as a misplaced second pulse. It reads the status register while a detection is in progress and checks `irq` in the very next cycle; a design that let the clear win over the set would drop the interrupt there. It also walks the reserved mode codes, where a decoder that treated them as duty-cycled would power the comparator.

// File: rtl/supmon_pkg.sv
package supmon_pkg;

  localparam int unsigned MODE_W = 3;
  typedef logic [MODE_W-1:0] mode_t;

  // Sampling mode codes; 5..7 are reserved and behave as off
  localparam mode_t MODE_OFF     = 3'd0;
  localparam mode_t MODE_CONT    = 3'd1;
  localparam mode_t MODE_P_SHORT = 3'd2;
  localparam mode_t MODE_P_MID   = 3'd3;
  localparam mode_t MODE_P_LONG  = 3'd4;
  localparam int unsigned DUTY_MODES = 3;

  // Register addresses
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_THRESH = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd2;

  // Field positions
  localparam int unsigned CTRL_IRQ_BIT    = 4;
  localparam int unsigned CTRL_RST_BIT    = 5;
  localparam int unsigned CTRL_WAKE_BIT   = 6;
  localparam int unsigned STAT_LIVE_BIT   = 0;
  localparam int unsigned STAT_STICKY_BIT = 1;

  typedef struct packed {
    logic  wake_en;
    logic  rst_en;
    logic  irq_en;
    mode_t mode;
  } ctrl_t;

endpackage

// File: rtl/supmon_rst_sync.sv
module supmon_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/supmon_regs.sv
module supmon_regs
  import supmon_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TH_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              live,
  input  logic              sticky,
  output logic [DATA_W-1:0] rdata,
  output logic [TH_W-1:0]   thresh,
  output ctrl_t             ctrl,
  output logic              mode_restart,
  output logic              status_rd
);

  logic [TH_W-1:0] thresh_q, thresh_d;
  ctrl_t           ctrl_q, ctrl_d;
  logic            wr_thresh, wr_ctrl;
  logic            unused_wdata;

  assign wr_thresh    = wr_en && (addr == ADDR_THRESH);
  assign wr_ctrl      = wr_en && (addr == ADDR_CTRL);
  assign unused_wdata = wdata[DATA_W-1];

  // next state
  always_comb begin
    thresh_d = thresh_q;
    ctrl_d   = ctrl_q;
    if (wr_thresh) thresh_d = wdata[TH_W-1:0];
    if (wr_ctrl) begin
      ctrl_d.mode    = wdata[MODE_W-1:0];
      ctrl_d.irq_en  = wdata[CTRL_IRQ_BIT];
      ctrl_d.rst_en  = wdata[CTRL_RST_BIT];
      ctrl_d.wake_en = wdata[CTRL_WAKE_BIT];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thresh_q <= '0;
      ctrl_q   <= '0;
    end else begin
      thresh_q <= thresh_d;
      ctrl_q   <= ctrl_d;
    end
  end

  // window restart only when the mode value actually changes
  assign mode_restart = wr_ctrl && (wdata[MODE_W-1:0] != ctrl_q.mode);
  assign status_rd    = rd_en && (addr == ADDR_STATUS);

  // read mux
  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_THRESH: rdata[TH_W-1:0] = thresh_q;
      ADDR_CTRL: begin
        rdata[MODE_W-1:0]    = ctrl_q.mode;
        rdata[CTRL_IRQ_BIT]  = ctrl_q.irq_en;
        rdata[CTRL_RST_BIT]  = ctrl_q.rst_en;
        rdata[CTRL_WAKE_BIT] = ctrl_q.wake_en;
      end
      ADDR_STATUS: begin
        rdata[STAT_LIVE_BIT]   = live;
        rdata[STAT_STICKY_BIT] = sticky;
      end
      default: rdata = '0;
    endcase
  end

  assign thresh = thresh_q;
  assign ctrl   = ctrl_q;

endmodule

// File: rtl/supmon_sampler.sv
module supmon_sampler
  import supmon_pkg::*;
#(
  parameter int unsigned P_SHORT = 32,
  parameter int unsigned P_MID   = 256,
  parameter int unsigned P_LONG  = 2048
) (
  input  logic  clk,
  input  logic  rst_n,
  input  mode_t mode,
  input  logic  restart,
  output logic  cmp_en
);

  localparam int unsigned CNT_W = $clog2(P_LONG);
  localparam int unsigned PERIODS [DUTY_MODES] = '{P_SHORT, P_MID, P_LONG};

  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [DUTY_MODES-1:0] sel;
  logic [DUTY_MODES-1:0] wrap_hit;
  logic                  duty, cont;

  for (genvar i = 0; i < DUTY_MODES; i++) begin : g_window
    assign sel[i]      = (mode == mode_t'(MODE_P_SHORT + i));
    assign wrap_hit[i] = sel[i] && (cnt_q == CNT_W'(PERIODS[i] - 1));
  end

  assign duty = |sel;
  assign cont = (mode == MODE_CONT);

  // next state
  always_comb begin
    if (restart || !duty || (|wrap_hit)) cnt_d = '0;
    else                                 cnt_d = cnt_q + 1'b1;
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cmp_en = cont || (duty && (cnt_q == '0));

endmodule

// File: rtl/supmon_detect.sv
module supmon_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_en,
  input  logic cmp_below,
  input  logic status_rd,
  input  logic irq_en,
  input  logic rst_en,
  input  logic wake_en,
  output logic detect,
  output logic live,
  output logic sticky,
  output logic irq,
  output logic core_rst_req,
  output logic core_wake_req
);

  logic live_q, live_d;
  logic sticky_q, sticky_d;
  logic rst_q, rst_d;
  logic wake_q, wake_d;

  assign detect = cmp_en && cmp_below;

  // next state: a fresh detection wins over a read clear
  always_comb begin
    live_d   = cmp_en ? cmp_below : live_q;
    sticky_d = detect || (sticky_q && !status_rd);
    rst_d    = detect && rst_en;
    wake_d   = detect && wake_en;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q   <= 1'b0;
      sticky_q <= 1'b0;
      rst_q    <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      live_q   <= live_d;
      sticky_q <= sticky_d;
      rst_q    <= rst_d;
      wake_q   <= wake_d;
    end
  end

  assign live          = live_q;
  assign sticky        = sticky_q;
  assign irq           = sticky_q && irq_en;
  assign core_rst_req  = rst_q;
  assign core_wake_req = wake_q;

endmodule

// File: rtl/supmon_ctrl.sv
module supmon_ctrl
  import supmon_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned TH_W    = 4,
  parameter int unsigned P_SHORT = 32,
  parameter int unsigned P_MID   = 256,
  parameter int unsigned P_LONG  = 2048
) (
  input  logic              clk_slow,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              cmp_below,
  output logic              cmp_en,
  output logic [TH_W-1:0]   cmp_thresh,
  output logic              irq,
  output logic              core_rst_req,
  output logic              core_wake_req
);

  logic  rst_n_sync;
  ctrl_t ctrl;
  logic  mode_restart;
  logic  status_rd;
  logic  live;
  logic  sticky;
  logic  detect;

  supmon_rst_sync u_rst_sync (
    .clk       (clk_slow),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  supmon_regs #(
    .DATA_W (DATA_W),
    .TH_W   (TH_W)
  ) u_regs (
    .clk          (clk_slow),
    .rst_n        (rst_n_sync),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .addr         (addr),
    .wdata        (wdata),
    .live         (live),
    .sticky       (sticky),
    .rdata        (rdata),
    .thresh       (cmp_thresh),
    .ctrl         (ctrl),
    .mode_restart (mode_restart),
    .status_rd    (status_rd)
  );

  supmon_sampler #(
    .P_SHORT (P_SHORT),
    .P_MID   (P_MID),
    .P_LONG  (P_LONG)
  ) u_sampler (
    .clk     (clk_slow),
    .rst_n   (rst_n_sync),
    .mode    (ctrl.mode),
    .restart (mode_restart),
    .cmp_en  (cmp_en)
  );

  supmon_detect u_detect (
    .clk           (clk_slow),
    .rst_n         (rst_n_sync),
    .cmp_en        (cmp_en),
    .cmp_below     (cmp_below),
    .status_rd     (status_rd),
    .irq_en        (ctrl.irq_en),
    .rst_en        (ctrl.rst_en),
    .wake_en       (ctrl.wake_en),
    .detect        (detect),
    .live          (live),
    .sticky        (sticky),
    .irq           (irq),
    .core_rst_req  (core_rst_req),
    .core_wake_req (core_wake_req)
  );

endmodule

// File: rtl/supmon_ctrl_chk.sv
module supmon_ctrl_chk
  import supmon_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input ctrl_t ctrl,
  input logic  restart,
  input logic  cmp_en,
  input logic  cmp_below,
  input logic  detect,
  input logic  live,
  input logic  sticky,
  input logic  status_rd,
  input logic  core_rst_req,
  input logic  core_wake_req
);

  logic duty_mode;
  assign duty_mode = ctrl.mode inside {MODE_P_SHORT, MODE_P_MID, MODE_P_LONG};

  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(duty_mode || ctrl.mode == MODE_CONT) |-> !cmp_en);

  p_cont_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.mode == MODE_CONT) |-> cmp_en);

  p_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_mode && cmp_en && !restart) |=> !cmp_en);

  p_live_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en |=> $stable(live));

  p_live_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_en |=> (live == $past(cmp_below)));

  p_sticky_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    detect |=> sticky);

  p_sticky_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky && !status_rd) |=> sticky);

  p_rst_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(detect && ctrl.rst_en) |=> !core_rst_req);

  p_wake_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(detect && ctrl.wake_en) |=> !core_wake_req);

endmodule

bind supmon_ctrl supmon_ctrl_chk u_chk (
  .clk           (clk_slow),
  .rst_n         (rst_n_sync),
  .ctrl          (ctrl),
  .restart       (mode_restart),
  .cmp_en        (cmp_en),
  .cmp_below     (cmp_below),
  .detect        (detect),
  .live          (live),
  .sticky        (sticky),
  .status_rd     (status_rd),
  .core_rst_req  (core_rst_req),
  .core_wake_req (core_wake_req)
);

// File: tb/tb_supmon_ctrl.sv
module tb_supmon_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] A_TH = 2'd0, A_CTRL = 2'd1, A_STAT = 2'd2;

  // {ctrl write value, cmp_en in 1st cycle after write, cmp_en in 2nd cycle}
  localparam logic [9:0] VEC [8] = '{
    {8'h00, 1'b0, 1'b0},
    {8'h11, 1'b1, 1'b1},
    {8'h22, 1'b1, 1'b0},
    {8'h43, 1'b1, 1'b0},
    {8'h74, 1'b1, 1'b0},
    {8'h05, 1'b0, 1'b0},
    {8'h16, 1'b0, 1'b0},
    {8'hF7, 1'b0, 1'b0}
  };

  logic       clk_slow = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en, cmp_below;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic       cmp_en, irq, core_rst_req, core_wake_req;
  logic [3:0] cmp_thresh;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk_slow = ~clk_slow;

  supmon_ctrl dut (
    .clk_slow      (clk_slow),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .rd_en         (rd_en),
    .addr          (addr),
    .wdata         (wdata),
    .rdata         (rdata),
    .cmp_below     (cmp_below),
    .cmp_en        (cmp_en),
    .cmp_thresh    (cmp_thresh),
    .irq           (irq),
    .core_rst_req  (core_rst_req),
    .core_wake_req (core_wake_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_slow);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk_slow);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_slow);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk_slow);
    rd_en = 1'b0;
    #1;
  endtask

  task automatic period(input logic [7:0] code, input int p, input string req);
    int hits = 0;
    int pos2 = -1;
    wr(A_CTRL, 8'h00);
    wr(A_CTRL, code);
    for (int k = 0; k < 2 * p; k++) begin
      if (cmp_en) begin
        hits++;
        if (hits == 2) pos2 = k;
      end
      @(negedge clk_slow); #1;
    end
    check(req, hits, 2);
    check(req, pos2, p);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; cmp_below = 1'b0;
    repeat (3) @(negedge clk_slow);
    rst_n = 1'b1;
    repeat (3) @(negedge clk_slow);
    #1;

    // reset state (R11)
    check("R11 reset cmp_en", cmp_en, 0);
    check("R11 reset outputs", {irq, core_rst_req, core_wake_req}, 0);
    check("R10 reset thresh", cmp_thresh, 0);
    rd(A_STAT, d); check("R11 reset status", d, 0);

    // threshold pass-through (R10, R11)
    wr(A_TH, 8'hFA);
    check("R10 thresh out", cmp_thresh, 4'hA);
    rd(A_TH, d); check("R11 thresh readback", d, 8'h0A);

    // mode table (R1, R2, R3, R11)
    for (int i = 0; i < 8; i++) begin
      wr(A_CTRL, VEC[i][9:2]);
      check("R1/R2/R3 first cycle", cmp_en, VEC[i][1]);
      @(negedge clk_slow); #1;
      check("R1/R2/R3 second cycle", cmp_en, VEC[i][0]);
      rd(A_CTRL, d); check("R11 ctrl readback", d, VEC[i][9:2] & 8'h77);
    end

    // window lengths (R3)
    period(8'h02, 32, "R3 period 32");
    period(8'h03, 256, "R3 period 256");
    period(8'h04, 2048, "R3 period 2048");

    // sampling only in enabled cycle (R4), reset request (R8), irq (R7)
    wr(A_CTRL, 8'h00);
    wr(A_CTRL, 8'h32);            // k=0, enabled cycle, cmp_below low
    @(negedge clk_slow);          // k=1
    cmp_below = 1'b1;
    repeat (18) @(negedge clk_slow); // k=19
    rd_en = 1'b1; addr = A_STAT;
    #1 check("R4 no sample between windows", rdata, 8'h00);
    check("R7 irq quiet", irq, 0);
    @(negedge clk_slow);          // k=20
    rd_en = 1'b0;
    repeat (12) @(negedge clk_slow); // k=32
    #1 check("R3 second window", cmp_en, 1);
    @(negedge clk_slow); #1;     // k=33
    check("R8 reset pulse", core_rst_req, 1);
    check("R9 wake gated off", core_wake_req, 0);
    check("R7 irq raised", irq, 1);
    cmp_below = 1'b0;
    @(negedge clk_slow);          // k=34
    #1 check("R8 pulse one cycle", core_rst_req, 0);
    rd_en = 1'b1; addr = A_STAT;
    #1 check("R4 R5 status after detect", rdata, 8'h03);
    @(negedge clk_slow);
    rd_en = 1'b0;
    #1 check("R5 sticky cleared by read", irq, 0);
    rd(A_STAT, d); check("R5 status after clear", d, 8'h01);

    // continuous mode, wake, read/detect collision (R2, R6, R9)
    wr(A_CTRL, 8'h51);
    rd(A_STAT, d); check("R2 live follows low", d, 8'h00);
    @(negedge clk_slow); cmp_below = 1'b1;
    @(negedge clk_slow); #1;
    check("R9 wake pulse", core_wake_req, 1);
    check("R8 reset gated off", core_rst_req, 0);
    rd(A_STAT, d); check("R2 live follows high", d, 8'h03);
    check("R6 sticky kept on collision", irq, 1);
    cmp_below = 1'b0;
    rd(A_STAT, d); check("R2 live back low", d, 8'h02);
    check("R5 sticky cleared", irq, 0);

    // irq gating (R7)
    wr(A_CTRL, 8'h01);
    @(negedge clk_slow); cmp_below = 1'b1;
    @(negedge clk_slow); cmp_below = 1'b0;
    #1 check("R7 irq masked", irq, 0);
    rd(A_STAT, d); check("R7 sticky set while masked", d, 8'h02);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule